// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for every received CAN frame header, whether the frame is wanted and which filter claimed it. A parameterised number of filter banks (28 by default) each hold two 32-bit words and a small control field. Software loads them through a simple write port. Each bank is configured separately. It works either as one wide filter over the whole identifier or as a pair of narrow filters over a condensed 16-bit key. In either width it compares against an identifier with a care mask, or against a set of exact identifiers.

A parsed header arrives as the standard identifier, the extended identifier, the IDE and RTR flags, and a one-cycle valid strobe. One clock later the block raises a one-cycle accept pulse together with the number of the winning filter and the FIFO-assignment bit of its bank. Exact-identifier filters take precedence over masked ones. Within a category the lowest filter number wins. A frame that no filter claims produces no accept pulse and leaves the index and FIFO outputs unchanged.

Top module: `can_id_filter`

## Requirements
- R1: Reset clears every bank's control field, so that no frame is accepted until a bank is made active. A write with `cfg_we` high stores `cfg_wdata` into the bank `cfg_bank`, selected by `cfg_sel`: 0 for the first word, 1 for the second word, 2 for control. The control bits are bit0 active, bit1 scale (1 = one 32-bit filter), bit2 mode (1 = exact list) and bit3 FIFO assignment.
- R2: The 32-bit key is {STD[10:0], EXT[17:0], IDE, RTR, 1'b0}. The 16-bit key is {STD[10:0], RTR, IDE, EXT[17:15]}.
- R3: In mask mode a filter hits when every key bit whose mask bit is 1 equals the identifier bit. Key bits whose mask bit is 0 are ignored. A 32-bit mask filter uses word 1 as the identifier and word 2 as the mask. Each 16-bit mask filter uses bits 15:0 of its word as the identifier and bits 31:16 as the mask, with word 1 as the first filter and word 2 as the second.
- R4: In list mode an entry hits only when the whole key equals it. A 32-bit list bank has two entries, word 1 then word 2.
- R5: A 16-bit list bank has four entries, in this order: word1[15:0], word1[31:16], word2[15:0], word2[31:16].
- R6: Filter numbers run across all banks in bank order, active or not. A bank takes 1 number (32-bit mask), 2 numbers (32-bit list or 16-bit mask) or 4 numbers (16-bit list), in the entry order of R3 to R5.
- R7: When any list-mode filter hits, the reported filter is a list-mode one, even if mask-mode filters also hit.
- R8: Within the winning category, the lowest-numbered hitting filter is reported.
- R9: Banks whose active bit is clear never hit.
- R10: `acc_hit` is high for exactly the one cycle after a `rx_valid` cycle whose frame hit, and never otherwise.
- R11: A frame with no hit leaves `acc_hit` low and `acc_idx`/`acc_fifo` at their previous values.
- R12: `acc_fifo` carries the FIFO-assignment bit of the bank that holds the reported filter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 word 1, 1 word 2, 2 control |
| cfg_bank | input | 5 | Bank being written |
| cfg_wdata | input | 32 | Write data |
| rx_valid | input | 1 | Frame header valid strobe |
| rx_std | input | 11 | Standard identifier |
| rx_ext | input | 18 | Extended identifier |
| rx_ide | input | 1 | Identifier-extension flag |
| rx_rtr | input | 1 | Remote-request flag |
| acc_hit | output | 1 | Accept pulse, one cycle after valid |
| acc_idx | output | 7 | Number of the matching filter |
| acc_fifo | output | 1 | FIFO assignment of the matching bank |

## Verification
The hardest cases to reach from the ports are those where filters compete. One frame must satisfy a list entry and a mask filter in different banks at once. Another must satisfy two filters of the same category, one of them placed at the far end of the bank range. The configuration mixes all four bank shapes and leaves an inactive, fully programmed bank in the middle, so that a high filter number can only come out right if every preceding bank is counted correctly. The frame vectors are then chosen so that several land in both categories, or twice in one category, at once.

// File: rtl/can_id_filter.sv
module can_id_filter #(
  parameter int NBANKS = 28
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [1:0]                      cfg_sel,
  input  logic [$clog2(NBANKS)-1:0]       cfg_bank,
  input  logic [31:0]                     cfg_wdata,
  input  logic                            rx_valid,
  input  logic [10:0]                     rx_std,
  input  logic [17:0]                     rx_ext,
  input  logic                            rx_ide,
  input  logic                            rx_rtr,
  output logic                            acc_hit,
  output logic [$clog2(4*NBANKS)-1:0]     acc_idx,
  output logic                            acc_fifo
);
  localparam int IDX_W = $clog2(4*NBANKS);

  logic [31:0]       wa_q [NBANKS];
  logic [31:0]       wb_q [NBANKS];
  logic [NBANKS-1:0] act_q, scale_q, mode_q, fifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= '0;
      scale_q <= '0;
      mode_q  <= '0;
      fifo_q  <= '0;
      for (int i = 0; i < NBANKS; i++) begin
        wa_q[i] <= '0;
        wb_q[i] <= '0;
      end
    end else if (cfg_we && (int'(cfg_bank) < NBANKS)) begin
      case (cfg_sel)
        2'd0: wa_q[cfg_bank] <= cfg_wdata;
        2'd1: wb_q[cfg_bank] <= cfg_wdata;
        2'd2: begin
          act_q[cfg_bank]   <= cfg_wdata[0];
          scale_q[cfg_bank] <= cfg_wdata[1];
          mode_q[cfg_bank]  <= cfg_wdata[2];
          fifo_q[cfg_bank]  <= cfg_wdata[3];
        end
        default: ;
      endcase
    end
  end

  wire [31:0] key32 = {rx_std, rx_ext, rx_ide, rx_rtr, 1'b0};
  wire [15:0] key16 = {rx_std, rx_rtr, rx_ide, rx_ext[17:15]};

  function automatic logic [2:0] bank_match(
    input logic        scl,
    input logic        md,
    input logic [31:0] wa,
    input logic [31:0] wb,
    input logic [31:0] k32,
    input logic [15:0] k16
  );
    logic [3:0] e;
    if (scl && md)
      e = {2'b00, k32 == wb, k32 == wa};
    else if (scl)
      e = {3'b000, ((k32 ^ wa) & wb) == 32'd0};
    else if (md)
      e = {k16 == wb[31:16], k16 == wb[15:0], k16 == wa[31:16], k16 == wa[15:0]};
    else
      e = {2'b00, ((k16 ^ wb[15:0]) & wb[31:16]) == 16'd0,
                  ((k16 ^ wa[15:0]) & wa[31:16]) == 16'd0};
    if (e[0])      bank_match = 3'b100;
    else if (e[1]) bank_match = 3'b101;
    else if (e[2]) bank_match = 3'b110;
    else if (e[3]) bank_match = 3'b111;
    else           bank_match = 3'b000;
  endfunction

  logic             list_found, mask_found;
  logic [IDX_W-1:0] list_idx, mask_idx;
  logic             list_fifo, mask_fifo;

  always_comb begin
    logic [IDX_W-1:0] base;
    logic [2:0]       m;
    logic [2:0]       cnt;
    base       = '0;
    list_found = 1'b0;
    mask_found = 1'b0;
    list_idx   = '0;
    mask_idx   = '0;
    list_fifo  = 1'b0;
    mask_fifo  = 1'b0;
    for (int b = 0; b < NBANKS; b++) begin
      m   = bank_match(scale_q[b], mode_q[b], wa_q[b], wb_q[b], key32, key16);
      cnt = scale_q[b] ? (mode_q[b] ? 3'd2 : 3'd1) : (mode_q[b] ? 3'd4 : 3'd2);
      if (act_q[b] && m[2]) begin
        if (mode_q[b] && !list_found) begin
          list_found = 1'b1;
          list_idx   = base + IDX_W'(m[1:0]);
          list_fifo  = fifo_q[b];
        end else if (!mode_q[b] && !mask_found) begin
          mask_found = 1'b1;
          mask_idx   = base + IDX_W'(m[1:0]);
          mask_fifo  = fifo_q[b];
        end
      end
      base = base + IDX_W'(cnt);
    end
  end

  wire any_hit = list_found | mask_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hit  <= 1'b0;
      acc_idx  <= '0;
      acc_fifo <= 1'b0;
    end else begin
      acc_hit <= rx_valid & any_hit;
      if (rx_valid && any_hit) begin
        acc_idx  <= list_found ? list_idx  : mask_idx;
        acc_fifo <= list_found ? list_fifo : mask_fifo;
      end
    end
  end
endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int NBANKS = 28,
  parameter int IDX_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             acc_hit,
  input logic [IDX_W-1:0] acc_idx,
  input logic             acc_fifo
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !acc_hit);

  assert_pulse_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> $past(rx_valid));

  assert_idx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> $stable(acc_idx));

  assert_fifo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> $stable(acc_fifo));

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> (int'(acc_idx) < 4*NBANKS));
endmodule

bind can_id_filter can_id_filter_chk #(.NBANKS(NBANKS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
  .acc_hit(acc_hit), .acc_idx(acc_idx), .acc_fifo(acc_fifo)
);

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [4:0]  cfg_bank = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic [10:0] rx_std = '0;
  logic [17:0] rx_ext = '0;
  logic        rx_ide = 1'b0;
  logic        rx_rtr = 1'b0;
  logic        acc_hit;
  logic [6:0]  acc_idx;
  logic        acc_fifo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_id_filter #(.NBANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_bank(cfg_bank), .cfg_wdata(cfg_wdata), .rx_valid(rx_valid),
    .rx_std(rx_std), .rx_ext(rx_ext), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
    .acc_hit(acc_hit), .acc_idx(acc_idx), .acc_fifo(acc_fifo)
  );

  // {std, ext, ide, rtr, exp_hit, exp_idx, exp_fifo}
  localparam logic [39:0] VEC [15] = '{
    {11'h123, 18'h0,     1'b0, 1'b0, 1'b1, 7'd2,  1'b1},
    {11'h123, 18'h0,     1'b0, 1'b1, 1'b1, 7'd0,  1'b0},
    {11'h100, 18'h5,     1'b1, 1'b0, 1'b1, 7'd1,  1'b1},
    {11'h100, 18'h6,     1'b1, 1'b0, 1'b1, 7'd8,  1'b1},
    {11'h050, 18'h0,     1'b0, 1'b0, 1'b1, 7'd3,  1'b0},
    {11'h051, 18'h0,     1'b0, 1'b0, 1'b1, 7'd4,  1'b0},
    {11'h052, 18'h0,     1'b0, 1'b1, 1'b1, 7'd5,  1'b0},
    {11'h052, 18'h0,     1'b0, 1'b0, 1'b1, 7'd7,  1'b1},
    {11'h7FF, 18'h0,     1'b0, 1'b0, 1'b1, 7'd6,  1'b0},
    {11'h7FF, 18'h3FFFF, 1'b1, 1'b1, 1'b1, 7'd8,  1'b1},
    {11'h3AA, 18'h0,     1'b0, 1'b0, 1'b1, 7'd55, 1'b0},
    {11'h000, 18'h0,     1'b0, 1'b0, 1'b0, 7'd55, 1'b0},
    {11'h200, 18'h0,     1'b0, 1'b0, 1'b0, 7'd55, 1'b0},
    {11'h000, 18'h0,     1'b0, 1'b1, 1'b0, 7'd55, 1'b0},
    {11'h055, 18'h0,     1'b1, 1'b0, 1'b1, 7'd7,  1'b1}
  };

  localparam string VEC_REQ [15] = '{
    "R7", "R3", "R4", "R3", "R5", "R5", "R5", "R3",
    "R8", "R2", "R9", "R11", "R11", "R11", "R8"
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 5'(bank); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [10:0] s, input logic [17:0] e, input logic i, input logic r);
    @(negedge clk);
    rx_valid = 1'b1; rx_std = s; rx_ext = e; rx_ide = i; rx_rtr = r;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic program_banks();
    // ctrl: bit0 active, bit1 scale, bit2 mode, bit3 fifo
    wr(0, 0, 32'h2460_0000); wr(0, 1, 32'hFFE0_0004); wr(0, 2, 32'h3);
    wr(1, 0, 32'h2000_002C); wr(1, 1, 32'h2460_0000); wr(1, 2, 32'hF);
    wr(2, 0, 32'h0A20_0A00); wr(2, 1, 32'hFFE0_0A50); wr(2, 2, 32'h5);
    wr(3, 0, 32'hFE00_0A00); wr(3, 1, 32'h0008_0008); wr(3, 2, 32'h9);
    wr(4, 0, 32'h7540_0000); wr(4, 1, 32'h7540_0000); wr(4, 2, 32'hE);
    wr(27, 0, 32'h7540_0000); wr(27, 1, 32'hFFE0_0000); wr(27, 2, 32'h7);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] last_idx;
    logic       last_fifo;
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    check(acc_hit == 1'b0, "R1", acc_hit, 0);
    check(acc_idx == 7'd0, "R1", acc_idx, 0);
    check(acc_fifo == 1'b0, "R1", acc_fifo, 0);
    rst_n = 1'b1;
    // R1: unconfigured banks accept nothing
    send(11'h123, 18'h0, 1'b0, 1'b0);
    check(acc_hit == 1'b0, "R1", acc_hit, 0);

    program_banks();
    last_idx  = 7'd0;
    last_fifo = 1'b0;
    for (int n = 0; n < 15; n++) begin
      logic [39:0] v;
      v = VEC[n];
      send(v[39:29], v[28:11], v[10], v[9]);
      check(acc_hit == v[8], VEC_REQ[n], acc_hit, v[8]);
      if (v[8]) begin
        check(acc_idx == v[7:1], VEC_REQ[n], acc_idx, v[7:1]);
        check(acc_fifo == v[0], "R12", acc_fifo, v[0]);
        last_idx  = v[7:1];
        last_fifo = v[0];
      end else begin
        check(acc_idx == last_idx, "R11", acc_idx, last_idx);
        check(acc_fifo == last_fifo, "R11", acc_fifo, last_fifo);
      end
      @(negedge clk);
      // R10: single-cycle pulse
      check(acc_hit == 1'b0, "R10", acc_hit, 0);
    end

    // R10: no pulse without a valid strobe, even with a matching header held
    @(negedge clk);
    rx_std = 11'h123; rx_ext = '0; rx_ide = 1'b0; rx_rtr = 1'b0;
    repeat (2) @(negedge clk);
    check(acc_hit == 1'b0, "R10", acc_hit, 0);

    // R1: reset mid-run clears configuration
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(11'h123, 18'h0, 1'b0, 1'b0);
    check(acc_hit == 1'b0, "R1", acc_hit, 0);
    check(acc_idx == 7'd0, "R1", acc_idx, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule